// File: doc/BRIEF.md
# Tape Pulse Width Bit Classifier

This block turns the read line of a tape drive into a stream of bits. Only falling edges of the line are treated as events. The block measures the time between one accepted falling edge and the next, counted in ticks of a cycle-rate enable. It compares that interval with a programmable threshold and emits a single bit for each accepted edge: a long interval gives a 1 and a short interval gives a 0. Typical encodings use a short pulse of about 432 ticks for a 0 and a long pulse of about 808 ticks for a 1, so the default threshold of 0x027C (636) ticks falls between them.

The raw line passes through a synchronizer before edge detection. The interval counter is reloaded on every accepted edge, so consecutive pulses are measured back to back with no dead time. The counter saturates at its maximum value rather than wrapping. An edge that follows the previous accepted edge too closely is treated as a glitch and dropped. Assembling the bits into bytes and finding frames is left to a downstream block.

Top module: `tape_pulse_classifier`

## Requirements
- R1: After reset, `bit_valid` is 0 and the threshold holds 0x027C.
- R2: Rising edges and steady levels on `tape_in` never produce a strobe. A strobe only follows a falling edge.
- R3: The interval is the number of clock cycles with `tick_en` high, counted from the cycle in which the previous accepted edge was evaluated, including that cycle, up to the current edge, excluding it. For reset, the start is the first clock after reset is released. The strobe carries `bit_value` = 1 when the interval is strictly greater than the threshold, and 0 otherwise (an interval equal to the threshold gives 0).
- R4: A clock cycle with `thresh_we` high loads `thresh_wdata` into the threshold. The new value governs every edge evaluated after that clock.
- R5: Every accepted edge restarts the measurement immediately, so the next interval starts in the same cycle that ends the previous one.
- R6: The interval counter saturates at 0xFFFF. Any longer gap reads as 0xFFFF and is classified against the threshold as such, which gives a 1 for any threshold below 0xFFFF.
- R7: A falling edge whose interval is below 16 ticks is a glitch. It produces no strobe and does not restart the measurement, so its ticks add to the next interval.
- R8: `bit_valid` is a single-cycle strobe. It is high during the cycle that follows the third rising clock edge after `tape_in` falls: two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Cycle-rate enable; the interval counts cycles in which it is high |
| tape_in | input | 1 | Raw, asynchronous tape read line |
| thresh_we | input | 1 | Threshold write strobe |
| thresh_wdata | input | 16 | New threshold value, in ticks |
| bit_valid | output | 1 | One-cycle strobe, one per accepted falling edge |
| bit_value | output | 1 | Classified bit: 1 for a long interval, 0 for a short one |

## Verification
Directed pulse trains sit one tick either side of the default and of rewritten thresholds. This separates a strict comparison from an inclusive one and shows whether a threshold write takes effect. Nominal short and long tape pulses check the default threshold against real encodings. Runs of minimum-length pulses expose any dead time after the counter restarts. Glitch sequences of 15, 16, 10 and 2 ticks show whether a rejected edge wrongly restarts the count. A 70000-cycle gap against a 0xFFFE threshold separates a saturating counter from a wrapping one. Random pulse lengths, random thresholds and gated or random tick enables compare each strobe, its cycle and its value with an interval the bench counts itself from the enables it drives.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

   localparam int unsigned TPC_MIN_CNT_W    = 8;
   localparam int unsigned TPC_MIN_STAGES   = 2;
   localparam int unsigned TPC_MAX_CNT_W    = 30;

   // Elaboration-time sanity check for the classifier parameters.
   function automatic bit tpc_params_ok(input int unsigned cnt_w,
                                        input int unsigned stages,
                                        input int unsigned glitch_min);
      bit ok;
      ok = (cnt_w >= TPC_MIN_CNT_W) && (cnt_w <= TPC_MAX_CNT_W) &&
           (stages >= TPC_MIN_STAGES);
      if (ok && (glitch_min >= (32'd1 << cnt_w)))
         ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   // stage_q[0..STAGES-1]: synchronizer, stage_q[STAGES]: previous level
   logic [STAGES:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stage_q[0] <= 1'b1;
      else        stage_q[0] <= din;
   end

   for (genvar g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage_q[g] <= 1'b1;
         else        stage_q[g] <= stage_q[g-1];
      end
   end

   assign fall = stage_q[STAGES] & ~stage_q[STAGES-1];

endmodule

// File: rtl/tpc_interval.sv
module tpc_interval #(
   parameter int unsigned W          = 16,
   parameter int unsigned GLITCH_MIN = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic         fall,
   output logic [W-1:0] count,
   output logic         accept
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
   localparam logic [W-1:0] GMIN_V  = W'(GLITCH_MIN);

   if (GLITCH_MIN == 0) begin : g_no_guard
      assign accept = fall;
   end else begin : g_guard
      assign accept = fall && (count >= GMIN_V);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (accept) begin
         // the evaluating cycle already belongs to the next interval
         count <= {{(W-1){1'b0}}, tick_en};
      end else if (tick_en && (count != CNT_MAX)) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/tpc_decide.sv
module tpc_decide #(
   parameter int unsigned    W          = 16,
   parameter logic [W-1:0]   THRESH_RST = W'(16'h027C),
   parameter bit             CMP_GE     = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         thr_we,
   input  logic [W-1:0] thr_wdata,
   input  logic         accept,
   input  logic [W-1:0] count,
   output logic [W-1:0] thresh,
   output logic         bit_valid,
   output logic         bit_value
);
   logic is_long;

   if (CMP_GE) begin : g_inclusive
      assign is_long = (count >= thresh);
   end else begin : g_strict
      assign is_long = (count > thresh);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      thresh <= THRESH_RST;
      else if (thr_we) thresh <= thr_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_valid <= 1'b0;
         bit_value <= 1'b0;
      end else begin
         bit_valid <= accept;
         if (accept) bit_value <= is_long;
      end
   end

endmodule

// File: rtl/tape_pulse_classifier.sv
module tape_pulse_classifier #(
   parameter int unsigned        CNT_W       = 16,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter int unsigned        GLITCH_MIN  = 16,
   parameter bit                 CMP_GE      = 1'b0,
   parameter logic [CNT_W-1:0]   THRESH_RST  = CNT_W'(16'h027C)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             tape_in,
   input  logic             thresh_we,
   input  logic [CNT_W-1:0] thresh_wdata,
   output logic             bit_valid,
   output logic             bit_value
);
   import tpc_pkg::*;

   if (!tpc_params_ok(CNT_W, SYNC_STAGES, GLITCH_MIN)) begin : g_bad_params
      $error("tape_pulse_classifier: illegal CNT_W, SYNC_STAGES or GLITCH_MIN");
   end

   logic             fall_w;
   logic             accept_w;
   logic [CNT_W-1:0] count_w;
   logic [CNT_W-1:0] thresh_w;

   tpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (tape_in),
      .fall (fall_w)
   );

   tpc_interval #(.W(CNT_W), .GLITCH_MIN(GLITCH_MIN)) u_interval (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_en(tick_en),
      .fall   (fall_w),
      .count  (count_w),
      .accept (accept_w)
   );

   tpc_decide #(.W(CNT_W), .THRESH_RST(THRESH_RST), .CMP_GE(CMP_GE)) u_decide (
      .clk      (clk),
      .rst_n    (rst_n),
      .thr_we   (thresh_we),
      .thr_wdata(thresh_wdata),
      .accept   (accept_w),
      .count    (count_w),
      .thresh   (thresh_w),
      .bit_valid(bit_valid),
      .bit_value(bit_value)
   );

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
   parameter int unsigned W      = 16,
   parameter int unsigned GMIN   = 16,
   parameter bit          CMP_GE = 1'b0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick_en,
   input logic         thr_we,
   input logic [W-1:0] thr_wdata,
   input logic         fall,
   input logic [W-1:0] count,
   input logic [W-1:0] thresh,
   input logic         bit_valid,
   input logic         bit_value
);
   localparam logic [W-1:0] GMIN_V = W'(GMIN);
   localparam logic [W-1:0] MAXV   = {W{1'b1}};

   // R2: no edge from the synchronizer, no strobe
   p_rise_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> !bit_valid);

   // R3: classification of an accepted edge
   p_decision_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && count >= GMIN_V) |=> (bit_valid &&
         bit_value == (CMP_GE ? ($past(count) >= $past(thresh))
                              : ($past(count) >  $past(thresh)))));

   // R4: threshold write lands next cycle
   p_thresh_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      thr_we |=> thresh == $past(thr_wdata));

   // R5: accepted edge restarts the count with no dead time
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && count >= GMIN_V) |=> count == {{(W-1){1'b0}}, $past(tick_en)});

   // R6: counter holds at its maximum
   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (count == MAXV && !fall) |=> count == MAXV);

   // R7: glitch gives no strobe
   p_glitch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && count < GMIN_V) |=> !bit_valid);

   // R7: glitch does not restart the count
   p_glitch_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && count < GMIN_V && tick_en) |=> count == W'($past(count) + 1'b1));

   // R8: strobe lasts one cycle
   p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> !bit_valid);

endmodule

bind tape_pulse_classifier tpc_checker #(
   .W(CNT_W), .GMIN(GLITCH_MIN), .CMP_GE(CMP_GE)
) u_tpc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .thr_we   (thresh_we),
   .thr_wdata(thresh_wdata),
   .fall     (fall_w),
   .count    (count_w),
   .thresh   (thresh_w),
   .bit_valid(bit_valid),
   .bit_value(bit_value)
);

// File: tb/test_tape_pulse_classifier.sv
module test_tape_pulse_classifier;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        tape_in = 1'b1;
   logic        thresh_we = 1'b0;
   logic [15:0] thresh_wdata = '0;
   logic        bit_valid;
   logic        bit_value;

   always #4 clk = ~clk;   // 125 MHz

   tape_pulse_classifier i_tape_pulse_classifier (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .tape_in     (tape_in),
      .thresh_we   (thresh_we),
      .thresh_wdata(thresh_wdata),
      .bit_valid   (bit_valid),
      .bit_value   (bit_value)
   );

   int          cyc = 0;
   int unsigned tick_cum = 0;
   int unsigned hist [8];
   int          vectors = 0;
   int          miscompares = 0;
   int          tick_mode = 0;
   int unsigned thr_model = 32'h027C;
   int unsigned last_acc = 0;
   int          pend_q [$];
   string       cur_tag = "R1";
   logic        prev_valid = 1'b0;
   bit          done = 1'b0;

   // Bench-side tick bookkeeping: hist[k%8] = ticks seen before posedge k.
   always @(posedge clk) begin
      hist[cyc % 8] <= tick_cum;
      if (rst_n && tick_en) tick_cum <= tick_cum + 1;
      cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      case (tick_mode)
         0:       tick_en = 1'b1;
         1:       tick_en = (cyc % 2 == 0);
         default: tick_en = ($urandom_range(0, 3) != 0);
      endcase
   end

   function automatic bit exp_bit(input int unsigned ticks, input int unsigned thr);
      return ticks > thr;
   endfunction

   // Monitor: each driven fall is evaluated exactly three cycles later (R8).
   always @(negedge clk) begin
      int          c0;
      int unsigned at_edge, ticks, sat;
      bit          ev;
      if (rst_n) begin
         if (pend_q.size() != 0 && pend_q[0] + 3 == cyc) begin
            c0      = pend_q.pop_front();
            at_edge = hist[(c0 + 2) % 8];
            ticks   = at_edge - last_acc;
            sat     = (ticks > 65535) ? 65535 : ticks;
            vectors++;
            if (sat < 16) begin
               if (bit_valid !== 1'b0) begin
                  miscompares++;
                  $display("FAIL R7: glitch of %0d ticks, bit_valid=%b expected 0",
                           sat, bit_valid);
               end
            end else begin
               ev       = exp_bit(sat, thr_model);
               last_acc = at_edge;
               if (bit_valid !== 1'b1 || bit_value !== ev) begin
                  miscompares++;
                  $display("FAIL %s: interval %0d thr %0d, valid=%b value=%b expected valid=1 value=%b",
                           (sat == 65535) ? "R6" : cur_tag, sat, thr_model,
                           bit_valid, bit_value, ev);
               end
            end
         end else if (bit_valid) begin
            miscompares++;
            $display("FAIL R2: strobe at cycle %0d with no falling edge due, actual 1 expected 0", cyc);
         end
         if (bit_valid && prev_valid) begin
            miscompares++;
            $display("FAIL R8: strobe wider than one cycle, actual 1 expected 0");
         end
         prev_valid = bit_valid;
      end
   end

   // Line falls n cycles after the previous fall, with one rising edge midway.
   task automatic gap(input int n);
      int h;
      h = n / 2;
      repeat (h) @(negedge clk);
      tape_in = 1'b1;
      repeat (n - h) @(negedge clk);
      tape_in = 1'b0;
      pend_q.push_back(cyc);
   endtask

   task automatic set_thr(input int unsigned v);
      while (pend_q.size() != 0) @(negedge clk);
      @(negedge clk);
      thresh_we    = 1'b1;
      thresh_wdata = v[15:0];
      thr_model    = v;
      @(negedge clk);
      thresh_we    = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      vectors++;
      if (bit_valid !== 1'b0) begin
         miscompares++;
         $display("FAIL R1: bit_valid after reset actual %b expected 0", bit_valid);
      end

      // R1: default threshold 0x027C, boundary 636 / 637
      cur_tag = "R1";
      gap(1000);
      gap(636);
      gap(637);

      // R3: nominal tape pulses, 8 ticks per tape unit
      cur_tag = "R3";
      gap(8 * 32'h36);
      gap(8 * 32'h65);
      gap(8 * 32'h36);

      // R4: rewritten threshold
      cur_tag = "R4";
      set_thr(100);
      gap(50);
      gap(100);
      gap(101);
      gap(99);

      // R5: back-to-back minimum-length pulses
      cur_tag = "R5";
      set_thr(20);
      gap(40);
      gap(16); gap(16); gap(21); gap(16); gap(22); gap(20);

      // R7: glitch rejection and accumulation
      cur_tag = "R7";
      set_thr(65);
      gap(40);
      gap(10);
      gap(60);
      gap(16);
      gap(15);
      gap(2);
      gap(40);

      // R2: long steady levels with a rising edge in between
      cur_tag = "R2";
      gap(3000);
      gap(64);

      // R3: gated and random tick enables
      cur_tag = "R3";
      set_thr(300);
      tick_mode = 1;
      gap(500);
      gap(700);
      gap(602);
      gap(600);
      tick_mode = 2;
      gap(420);
      gap(380);
      tick_mode = 0;

      // R6: saturation
      cur_tag = "R6";
      set_thr(32'hFFFE);
      gap(20);
      gap(70000);
      gap(100);

      // Random mix
      cur_tag = "R3";
      set_thr(32'h027C);
      for (int i = 0; i < 80; i++) begin
         int n;
         if (i % 16 == 8) set_thr($urandom_range(20, 900));
         tick_mode = $urandom_range(0, 2);
         if ($urandom_range(0, 9) == 0) n = $urandom_range(2, 15);
         else                           n = $urandom_range(16, 1000);
         gap(n);
      end
      tick_mode = 0;

      while (pend_q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog R8: run hung, actual not finished expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule